// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block decides which of a fixed set of local interrupt receivers an interrupt message reaches. A message carries an 8-bit destination, a bit choosing physical or logical addressing, a 2-bit shorthand and a 3-bit delivery mode. Each receiver slot supplies its own configuration as inputs:
- a population flag,
- an 8-bit identifier,
- an 8-bit logical-destination byte,
- a 4-bit addressing-model field.

The block turns the message into a receiver mask. When the delivery mode asks for lowest-priority delivery, it also produces a one-hot mask. When the delivery mode is a special event, it produces a per-receiver event mask.

The block is a two-state controller. In `ST_IDLE` nothing is being presented. A `msg_valid` strobe in any state takes the transition `CAPTURE`, which registers the resolved masks and enters `ST_EMIT`. In `ST_EMIT`, `out_valid` is high for that one cycle. Without a new strobe, the transition `RETIRE` returns the controller to `ST_IDLE`. With a new strobe, `CAPTURE` is taken again and the controller stays in `ST_EMIT`. The mask outputs keep their last values until the next capture.

Top module: `irq_dest_resolver`

## Requirements
- R1: With shorthand 0 and physical mode (`msg_logical`=0), destination 0xFF selects every populated receiver.
- R2: With shorthand 0 and physical mode, any other destination selects only the lowest-indexed populated receiver whose identifier equals it. If no populated identifier matches, nothing is selected.
- R3: With shorthand 0 and logical mode (`msg_logical`=1), a receiver whose model field is 0xF is selected when the destination AND its logical byte is nonzero.
- R4: With shorthand 0 and logical mode, a receiver whose model field is 0x0 is selected when:
  - the upper nibbles of the destination and of its logical byte are equal, and
  - the lower nibbles of the two share at least one set bit.
- R5: With shorthand 0 and logical mode, a receiver whose model field is neither 0xF nor 0x0 is never selected.
- R6: Shorthand 1 selects only the receiver named by `sender_idx`. The destination and mode bit have no effect.
- R7: Shorthand 2 selects every populated receiver. Shorthand 3 selects every populated receiver except the sender. The destination has no effect in either case.
- R8: When the delivery mode is 1 (lowest priority), `lowpri_mask` holds only the lowest set bit of `deliver_mask`. For any other delivery mode, `lowpri_mask` is zero.
- R9: When the delivery mode is 2, 4 or 5 (special events), `event_mask` equals `deliver_mask`. For the codes 0, 1, 3, 6 and 7, `event_mask` is zero.
- R10: Bits of every mask that belong to unpopulated slots are zero.
- R11: The masks are registered at the clock edge that samples `msg_valid`=1. `out_valid` is high for exactly the cycle after each such edge.
- R12: After reset, `out_valid` and all masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Message strobe |
| msg_dest | input | 8 | Destination field |
| msg_logical | input | 1 | 0 = physical, 1 = logical addressing |
| msg_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| msg_dmode | input | 3 | Delivery mode code |
| sender_idx | input | SW | Index of the requesting receiver |
| unit_present | input | N | Slot population flags |
| unit_id | input | 8*N | Identifiers, slot i at bits [8i+7:8i] |
| unit_ldest | input | 8*N | Logical bytes, slot i at bits [8i+7:8i] |
| unit_model | input | 4*N | Model fields, slot i at bits [4i+3:4i] |
| out_valid | output | 1 | Result strobe |
| deliver_mask | output | N | Resolved receivers |
| lowpri_mask | output | N | One-hot lowest-priority pick |
| event_mask | output | N | Receivers raising a special event |

## Verification
The random patterns draw identifiers from a small range, so duplicate and missing matches happen often. These cases separate first-match selection from an OR of all matches. The model fields are drawn from flat, cluster and other values, which shows whether each receiver applies its own rule. Directed cases cover the following:
- broadcast against an unmatched identifier;
- cluster nibbles that match in the upper half but not the lower;
- each shorthand with a destination that would otherwise select nothing;
- lowest-priority delivery with an empty mask;
- a sender slot that is unpopulated.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'd0,
        DM_LOWEST  = 3'd1,
        DM_SMI     = 3'd2,
        DM_RSVD    = 3'd3,
        DM_NMI     = 3'd4,
        DM_INIT    = 3'd5,
        DM_STARTUP = 3'd6,
        DM_EXTINT  = 3'd7
    } dmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

    function automatic logic is_event_mode(input logic [2:0] m);
        return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT);
    endfunction
endpackage

// File: rtl/dest_match_unit.sv
module dest_match_unit
    import irq_dest_pkg::*;
(
    input  logic       present,
    input  logic [7:0] dest,
    input  logic [7:0] id,
    input  logic [7:0] ldest,
    input  logic [3:0] model,
    output logic       phys_hit,
    output logic       log_hit
);
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        phys_hit = present && (id == dest);
        flat_hit = (model == MODEL_FLAT) && ((dest & ldest) != 8'h00);
        clus_hit = (model == MODEL_CLUSTER)
                && (dest[7:4] == ldest[7:4])
                && ((dest[3:0] & ldest[3:0]) != 4'h0);
        log_hit  = present && (flat_hit || clus_hit);
    end
endmodule

// File: rtl/first_set_pick.sv
module first_set_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] pick
);
    // Isolate the least significant set bit: x & -x.
    always_comb pick = vec & (~vec + W'(1));
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int N  = 8,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_valid,
    input  logic [7:0]      msg_dest,
    input  logic            msg_logical,
    input  logic [1:0]      msg_shorthand,
    input  logic [2:0]      msg_dmode,
    input  logic [SW-1:0]   sender_idx,
    input  logic [N-1:0]    unit_present,
    input  logic [N*8-1:0]  unit_id,
    input  logic [N*8-1:0]  unit_ldest,
    input  logic [N*4-1:0]  unit_model,
    output logic            out_valid,
    output logic [N-1:0]    deliver_mask,
    output logic [N-1:0]    lowpri_mask,
    output logic [N-1:0]    event_mask
);
    logic [N-1:0] phys_vec, log_vec, self_vec, phys_first;
    logic [N-1:0] field_sel, resolved, lowest_pick;
    logic [N-1:0] nxt_lowpri, nxt_event;
    state_e       state_q, state_d;

    for (genvar i = 0; i < N; i++) begin : g_unit
        dest_match_unit u_match (
            .present  (unit_present[i]),
            .dest     (msg_dest),
            .id       (unit_id[i*8 +: 8]),
            .ldest    (unit_ldest[i*8 +: 8]),
            .model    (unit_model[i*4 +: 4]),
            .phys_hit (phys_vec[i]),
            .log_hit  (log_vec[i])
        );
        assign self_vec[i] = unit_present[i] && (sender_idx == SW'(i));
    end

    first_set_pick #(.W(N)) u_phys_first (.vec(phys_vec), .pick(phys_first));
    first_set_pick #(.W(N)) u_low_pick   (.vec(resolved), .pick(lowest_pick));

    always_comb begin
        if (msg_logical)
            field_sel = log_vec;
        else if (msg_dest == DEST_BCAST)
            field_sel = unit_present;
        else
            field_sel = phys_first;

        unique case (shorthand_e'(msg_shorthand))
            SH_FIELD:  resolved = field_sel;
            SH_SELF:   resolved = self_vec;
            SH_ALL:    resolved = unit_present;
            SH_OTHERS: resolved = unit_present & ~self_vec;
            default:   resolved = '0;
        endcase

        nxt_lowpri = (msg_dmode == DM_LOWEST) ? lowest_pick : '0;
        nxt_event  = is_event_mode(msg_dmode) ? resolved : '0;
    end

    // Next-state logic: CAPTURE on strobe, RETIRE otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = msg_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = msg_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deliver_mask <= '0;
            lowpri_mask  <= '0;
            event_mask   <= '0;
        end else if (msg_valid) begin
            deliver_mask <= resolved;
            lowpri_mask  <= nxt_lowpri;
            event_mask   <= nxt_event;
        end
    end

    always_comb out_valid = (state_q == ST_EMIT);

    assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> out_valid);
    assert_no_stray_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(msg_valid));
    assert_absent_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((deliver_mask & ~$past(unit_present)) == '0));
    assert_lowpri_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lowpri_mask) && ((lowpri_mask & ~deliver_mask) == '0));
    assert_event_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_event_mode($past(msg_dmode))) |-> (event_mask == '0));
    assert_self_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(msg_shorthand) == 2'd1) |-> ($countones(deliver_mask) <= 1));
endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;
    localparam int N  = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_valid = 1'b0;
    logic [7:0] msg_dest = '0;
    logic msg_logical = 1'b0;
    logic [1:0] msg_shorthand = '0;
    logic [2:0] msg_dmode = '0;
    logic [SW-1:0] sender_idx = '0;
    logic [N-1:0] unit_present = '0;
    logic [N*8-1:0] unit_id = '0;
    logic [N*8-1:0] unit_ldest = '0;
    logic [N*4-1:0] unit_model = '0;
    logic out_valid;
    logic [N-1:0] deliver_mask, lowpri_mask, event_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_dest_resolver #(.N(N), .SW(SW)) u_irq_dest_resolver (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .msg_shorthand(msg_shorthand),
        .msg_dmode(msg_dmode), .sender_idx(sender_idx),
        .unit_present(unit_present), .unit_id(unit_id),
        .unit_ldest(unit_ldest), .unit_model(unit_model),
        .out_valid(out_valid), .deliver_mask(deliver_mask),
        .lowpri_mask(lowpri_mask), .event_mask(event_mask)
    );

    function automatic logic [N-1:0] exp_mask();
        logic [N-1:0] m = '0;
        case (msg_shorthand)
            2'd0: begin
                if (!msg_logical) begin
                    if (msg_dest == 8'hFF) m = unit_present;
                    else
                        for (int i = N - 1; i >= 0; i--)
                            if (unit_present[i] && unit_id[i*8 +: 8] == msg_dest) m = N'(1) << i;
                end else begin
                    for (int i = 0; i < N; i++) begin
                        logic [7:0] ld = unit_ldest[i*8 +: 8];
                        logic [3:0] md = unit_model[i*4 +: 4];
                        if (unit_present[i]) begin
                            if (md == 4'hF && (msg_dest & ld) != 0) m[i] = 1'b1;
                            if (md == 4'h0 && msg_dest[7:4] == ld[7:4] && (msg_dest[3:0] & ld[3:0]) != 0) m[i] = 1'b1;
                        end
                    end
                end
            end
            2'd1: m[sender_idx] = unit_present[sender_idx];
            2'd2: m = unit_present;
            default: begin m = unit_present; m[sender_idx] = 1'b0; end
        endcase
        return m;
    endfunction

    function automatic logic [N-1:0] exp_low(input logic [N-1:0] m);
        if (msg_dmode != 3'd1) return '0;
        for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
        return '0;
    endfunction

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic send(input string req);
        logic [N-1:0] em, el, ee;
        em = exp_mask();
        el = exp_low(em);
        ee = (msg_dmode == 3'd2 || msg_dmode == 3'd4 || msg_dmode == 3'd5) ? em : '0;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R11", "out_valid high", N'(out_valid), N'(1));
        chk(req, "deliver_mask", deliver_mask, em);
        chk("R8", "lowpri_mask", lowpri_mask, el);
        chk("R9", "event_mask", event_mask, ee);
        @(negedge clk);
        chk("R11", "out_valid low", N'(out_valid), N'(0));
    endtask

    task automatic set_msg(input logic [7:0] d, input logic lg, input logic [1:0] sh, input logic [2:0] dm, input logic [SW-1:0] s);
        msg_dest = d; msg_logical = lg; msg_shorthand = sh; msg_dmode = dm; sender_idx = s;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        chk("R12", "reset deliver", deliver_mask, '0);
        chk("R12", "reset lowpri", lowpri_mask, '0);
        chk("R12", "reset event", event_mask, '0);
        chk("R12", "reset valid", N'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed configuration
        unit_present = 8'b1011_1110;
        for (int i = 0; i < N; i++) begin
            unit_id[i*8 +: 8]    = 8'(i + 16);
            unit_ldest[i*8 +: 8] = 8'(1 << i);
            unit_model[i*4 +: 4] = 4'hF;
        end
        set_msg(8'hFF, 1'b0, 2'd0, 3'd0, 3'd1); send("R1");
        set_msg(8'h10, 1'b0, 2'd0, 3'd0, 3'd1); send("R2"); // slot 0 absent -> none
        set_msg(8'h55, 1'b0, 2'd0, 3'd0, 3'd1); send("R2"); // no match
        unit_id[5*8 +: 8] = 8'h13; // duplicate of slot 3
        set_msg(8'h13, 1'b0, 2'd0, 3'd1, 3'd1); send("R2");
        set_msg(8'h28, 1'b1, 2'd0, 3'd2, 3'd1); send("R3");
        unit_model[3*4 +: 4] = 4'h0; unit_ldest[3*8 +: 8] = 8'h52;
        unit_model[4*4 +: 4] = 4'h0; unit_ldest[4*8 +: 8] = 8'h54;
        set_msg(8'h52, 1'b1, 2'd0, 3'd4, 3'd1); send("R4");
        set_msg(8'h62, 1'b1, 2'd0, 3'd4, 3'd1); send("R4");
        unit_model[2*4 +: 4] = 4'h7;
        set_msg(8'hFF, 1'b1, 2'd0, 3'd5, 3'd1); send("R5");
        set_msg(8'h00, 1'b0, 2'd1, 3'd6, 3'd3); send("R6");
        set_msg(8'h00, 1'b0, 2'd1, 3'd4, 3'd0); send("R6"); // absent sender
        set_msg(8'h00, 1'b1, 2'd2, 3'd1, 3'd2); send("R7");
        set_msg(8'h00, 1'b0, 2'd3, 3'd1, 3'd1); send("R7");
        unit_present = '0;
        set_msg(8'hFF, 1'b0, 2'd0, 3'd1, 3'd1); send("R10");

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            unit_present = 8'($urandom());
            for (int i = 0; i < N; i++) begin
                int sel;
                unit_id[i*8 +: 8]    = 8'($urandom_range(0, 7));
                unit_ldest[i*8 +: 8] = 8'($urandom());
                sel = int'($urandom_range(0, 4));
                unit_model[i*4 +: 4] = (sel < 2) ? 4'hF : (sel < 4) ? 4'h0 : 4'($urandom_range(1, 14));
            end
            set_msg(($urandom_range(0, 5) == 0) ? 8'hFF :
                    ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 9)) : 8'($urandom()),
                    1'($urandom()), 2'($urandom()), 3'($urandom()), 3'($urandom()));
            send("R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule